// File: doc/BRIEF.md
# Processing-Element I/O Step Sequencer

This block drives the communication side of one processing element in an array of cooperating processors. It walks a looped program of operation sets that is held in an external memory. Each set names the incoming links to read from and the outgoing links to write to, and it can also carry a minimum step count. On every clock step the sequencer raises a request for each operation in the current set that is still outstanding. It records completions as they arrive, and a set's operations may finish on different cycles. The program counter moves on only when three things hold at once: every operation of the set is finished, the step count of the set has run out, and the progress rule of the selected execution mode allows it.

There are five progress rules:
- Lockstep: all link traffic must be quiet.
- Flow: no reader may be waiting on this element.
- Bounded flow: as flow, and no outgoing link may also hold more than a fixed number of unread values.
- Demand: some reader must be waiting, and no outgoing link may be over that bound.
- Free-running: only the operations and the step count matter.

The rule and the loop-start index are captured once after reset. This lets the same program be compared under different execution disciplines. Data values are not handled; only the sequencing of transfers is modelled.

Top module: `pe_io_sequencer`

## Requirements
- R1: While reset is low, and on the first cycle after it is released, prog_addr is 0 and no request is raised. From the second cycle on, every read and write of set 0 is requested.
- R2: mode_sel and loop_start are captured on the first clock edge after reset. Later changes to them have no effect until the next reset.
- R3: A request stays high until its completion input is seen high together with it. The completion is then remembered and the request drops on the next cycle, while other operations of the set stay requested.
- R4: step_adv is high only in a cycle where every operation of the set is complete, counting the completions seen in that cycle. After a step_adv, prog_addr moves to the next index; otherwise it holds.
- R5: A completion pulse on a link that has no request raised is ignored and does not complete anything.
- R6: In a set with its loop-end bit (bit 13) set, a step_adv returns prog_addr to the captured loop-start index.
- R7: In free-running mode (code 4), a set with its delay-enable bit (bit 8) set and delay value n (bits 12:9) stays current for at least n cycles. A value of 0 counts as 1. A set without a delay can finish in its first cycle.
- R8: In every mode other than free-running, the delay field is ignored and a set can finish in its first cycle.
- R9: Lockstep mode (code 0) allows advance only when every out_level is 0, no out_wait bit is set and no in_busy bit is set.
- R10: Flow mode (code 1) blocks advance when any out_wait bit is set. It ignores out_level and in_busy.
- R11: Bounded flow mode (code 2) blocks advance when any out_wait bit is set or any out_level exceeds BOUND (default 2). It ignores in_busy.
- R12: Demand mode (code 3) allows advance only when at least one out_wait bit is set and no out_level exceeds BOUND.
- R13: Mode codes 5 to 7 behave as lockstep.

Set word layout (4 links): bits 3:0 read enables, bits 7:4 write enables, bit 8 delay enable, bits 12:9 delay value, bit 13 loop end. Link j of out_level sits in bits 3j+2:3j.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| mode_sel | input | 3 | Execution mode code, captured after reset |
| loop_start | input | 4 | Index the program returns to after a loop-end set |
| prog_addr | output | 4 | Index of the current operation set |
| prog_word | input | 14 | Operation set read combinationally at prog_addr |
| rd_req | output | 4 | Read requested on each incoming link |
| rd_done | input | 4 | Read completed on each incoming link |
| wr_req | output | 4 | Write requested on each outgoing link |
| wr_done | input | 4 | Write completed on each outgoing link |
| out_level | input | 12 | Unread written values held on each outgoing link, 3 bits per link |
| out_wait | input | 4 | Reader at the far end of each outgoing link is waiting |
| in_busy | input | 4 | Each incoming link has traffic pending |
| step_adv | output | 1 | Current set completes in this cycle |

## Verification
step_adv and the request outputs are combinational from the current set, the captured state and the present link inputs. The bench therefore drives the inputs just after a falling edge and reads these outputs one time unit later, in the same cycle. prog_addr and the drop of a completed request are registered and show one clock edge later, so the bench reads them in the cycle after the stimulus. Mode rules are checked on a one-set looping program, where step_adv reflects the progress rule alone. Delays are counted cycle by cycle from the first cycle the set is current.

// File: rtl/pe_seq_pkg.sv
package pe_seq_pkg;

  typedef enum logic [2:0] {
    MODE_LOCKSTEP     = 3'd0,
    MODE_FLOW         = 3'd1,
    MODE_FLOW_BOUNDED = 3'd2,
    MODE_DEMAND       = 3'd3,
    MODE_FREE         = 3'd4
  } run_mode_e;

  // Unused codes fall back to the strictest rule.
  function automatic run_mode_e decode_mode(input logic [2:0] code);
    case (code)
      3'd1:    decode_mode = MODE_FLOW;
      3'd2:    decode_mode = MODE_FLOW_BOUNDED;
      3'd3:    decode_mode = MODE_DEMAND;
      3'd4:    decode_mode = MODE_FREE;
      default: decode_mode = MODE_LOCKSTEP;
    endcase
  endfunction

endpackage

// File: rtl/seq_op_tracker.sv
module seq_op_tracker #(
  parameter int NLINK = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             clr,
  input  logic [NLINK-1:0] op_en,
  input  logic [NLINK-1:0] op_done,
  output logic [NLINK-1:0] op_req,
  output logic             all_done
);

  logic [NLINK-1:0] got_q;
  logic [NLINK-1:0] got_d;
  logic [NLINK-1:0] complete;

  for (genvar j = 0; j < NLINK; j++) begin : g_link
    always_comb begin
      op_req[j]   = run & op_en[j] & ~got_q[j];
      complete[j] = ~op_en[j] | got_q[j] | op_done[j];
      if (clr) begin
        got_d[j] = 1'b0;
      end else begin
        got_d[j] = got_q[j] | (op_req[j] & op_done[j]);
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        got_q[j] <= 1'b0;
      end else if (run) begin
        got_q[j] <= got_d[j];
      end
    end

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (op_req[j] && !op_done[j]) |=> op_req[j]) else $error("request dropped early"); // R3
    AST_REQ_RETIRED: assert property (@(posedge clk) disable iff (!rst_n)
      (op_req[j] && op_done[j] && !clr) |=> !op_req[j]) else $error("request not retired"); // R3
  end

  assign all_done = &complete;

endmodule

// File: rtl/seq_step_timer.sv
module seq_step_timer #(
  parameter int DLY_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             clr,
  input  logic             use_delay,
  input  logic             dly_en,
  input  logic [DLY_W-1:0] dly_val,
  output logic             expired
);

  localparam logic [DLY_W-1:0] STEP_MAX = {DLY_W{1'b1}};
  localparam logic [DLY_W-1:0] ONE      = {{(DLY_W-1){1'b0}}, 1'b1};

  logic [DLY_W-1:0] steps_q;
  logic [DLY_W-1:0] steps_d;
  logic [DLY_W-1:0] need;
  logic [DLY_W:0]   seen;

  always_comb begin
    if (use_delay && dly_en && (dly_val != '0)) begin
      need = dly_val;
    end else begin
      need = ONE;
    end
    seen    = {1'b0, steps_q} + {1'b0, ONE};
    expired = (seen >= {1'b0, need});
    if (clr) begin
      steps_d = '0;
    end else if (steps_q == STEP_MAX) begin
      steps_d = steps_q;
    end else begin
      steps_d = steps_q + ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      steps_q <= '0;
    end else if (run) begin
      steps_q <= steps_d;
    end
  end

  AST_NO_EARLY_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !clr && !expired && !$isunknown(steps_q)) |=> (steps_q != '0)) else $error("count lost"); // R7

endmodule

// File: rtl/seq_mode_gate.sv
module seq_mode_gate
  import pe_seq_pkg::*;
#(
  parameter int NLINK = 4,
  parameter int LVL_W = 3,
  parameter int BOUND = 2
) (
  input  run_mode_e              mode,
  input  logic [NLINK*LVL_W-1:0] out_level,
  input  logic [NLINK-1:0]       out_wait,
  input  logic [NLINK-1:0]       in_busy,
  output logic                   permit
);

  localparam logic [LVL_W-1:0] LIMIT = LVL_W'(BOUND);

  logic [NLINK-1:0] holds_data;
  logic [NLINK-1:0] over_limit;

  for (genvar j = 0; j < NLINK; j++) begin : g_link
    assign holds_data[j] = (out_level[j*LVL_W +: LVL_W] != '0);
    assign over_limit[j] = (out_level[j*LVL_W +: LVL_W] > LIMIT);
  end

  always_comb begin
    case (mode)
      MODE_FLOW:         permit = ~(|out_wait);
      MODE_FLOW_BOUNDED: permit = ~(|out_wait) & ~(|over_limit);
      MODE_DEMAND:       permit = (|out_wait) & ~(|over_limit);
      MODE_FREE:         permit = 1'b1;
      default:           permit = ~(|out_wait) & ~(|in_busy) & ~(|holds_data);
    endcase
  end

endmodule

// File: rtl/pe_io_sequencer.sv
module pe_io_sequencer
  import pe_seq_pkg::*;
#(
  parameter int NLINK = 4,
  parameter int PC_W  = 4,
  parameter int DLY_W = 4,
  parameter int LVL_W = 3,
  parameter int BOUND = 2,
  localparam int WORD_W = 2*NLINK + DLY_W + 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [2:0]             mode_sel,
  input  logic [PC_W-1:0]        loop_start,
  output logic [PC_W-1:0]        prog_addr,
  input  logic [WORD_W-1:0]      prog_word,
  output logic [NLINK-1:0]       rd_req,
  input  logic [NLINK-1:0]       rd_done,
  output logic [NLINK-1:0]       wr_req,
  input  logic [NLINK-1:0]       wr_done,
  input  logic [NLINK*LVL_W-1:0] out_level,
  input  logic [NLINK-1:0]       out_wait,
  input  logic [NLINK-1:0]       in_busy,
  output logic                   step_adv
);

  localparam int RD_LO   = 0;
  localparam int WR_LO   = NLINK;
  localparam int DEN_BIT = 2*NLINK;
  localparam int DLY_LO  = 2*NLINK + 1;
  localparam int END_BIT = 2*NLINK + DLY_W + 1;
  localparam logic [PC_W-1:0] PC_ONE = {{(PC_W-1){1'b0}}, 1'b1};

  // Captured configuration and sequencing state
  run_mode_e       mode_q, mode_d;
  logic [PC_W-1:0] loop_q, loop_d;
  logic [PC_W-1:0] pc_q, pc_d;
  logic            run_q;

  // Set word fields
  logic [NLINK-1:0] set_rd;
  logic [NLINK-1:0] set_wr;
  logic             set_den;
  logic [DLY_W-1:0] set_dly;
  logic             set_end;

  logic rd_all, wr_all, timer_ok, permit, advance;

  assign set_rd  = prog_word[RD_LO +: NLINK];
  assign set_wr  = prog_word[WR_LO +: NLINK];
  assign set_den = prog_word[DEN_BIT];
  assign set_dly = prog_word[DLY_LO +: DLY_W];
  assign set_end = prog_word[END_BIT];

  seq_op_tracker #(.NLINK(NLINK)) i_rd_track (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run_q),
    .clr      (advance),
    .op_en    (set_rd),
    .op_done  (rd_done),
    .op_req   (rd_req),
    .all_done (rd_all)
  );

  seq_op_tracker #(.NLINK(NLINK)) i_wr_track (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run_q),
    .clr      (advance),
    .op_en    (set_wr),
    .op_done  (wr_done),
    .op_req   (wr_req),
    .all_done (wr_all)
  );

  seq_step_timer #(.DLY_W(DLY_W)) i_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run_q),
    .clr       (advance),
    .use_delay (mode_q == MODE_FREE),
    .dly_en    (set_den),
    .dly_val   (set_dly),
    .expired   (timer_ok)
  );

  seq_mode_gate #(.NLINK(NLINK), .LVL_W(LVL_W), .BOUND(BOUND)) i_gate (
    .mode      (mode_q),
    .out_level (out_level),
    .out_wait  (out_wait),
    .in_busy   (in_busy),
    .permit    (permit)
  );

  assign advance = run_q & rd_all & wr_all & timer_ok & permit;

  // Next-state logic
  always_comb begin
    mode_d = mode_q;
    loop_d = loop_q;
    pc_d   = pc_q;
    if (!run_q) begin
      mode_d = decode_mode(mode_sel);
      loop_d = loop_start;
    end
    if (advance) begin
      if (set_end) begin
        pc_d = loop_q;
      end else begin
        pc_d = pc_q + PC_ONE;
      end
    end
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_LOCKSTEP;
      loop_q <= '0;
      pc_q   <= '0;
      run_q  <= 1'b0;
    end else begin
      run_q <= 1'b1;
      if (!run_q) begin
        mode_q <= mode_d;
        loop_q <= loop_d;
      end
      if (run_q) begin
        pc_q <= pc_d;
      end
    end
  end

  assign prog_addr = pc_q;
  assign step_adv  = advance;

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |-> (rd_req == '0 && wr_req == '0 && pc_q == '0)) else $error("idle not quiet"); // R1
  AST_CONFIG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |=> ($stable(mode_q) && $stable(loop_q))) else $error("config changed"); // R2
  AST_ADV_ALL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    step_adv |-> ((rd_req & ~rd_done) == '0 && (wr_req & ~wr_done) == '0)) else $error("advance with open op"); // R4
  AST_PC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !step_adv |=> $stable(prog_addr)) else $error("pc moved"); // R4
  AST_PC_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (step_adv && !set_end) |=> (prog_addr == $past(prog_addr) + PC_ONE)) else $error("pc skip"); // R4
  AST_LOOP_BACK: assert property (@(posedge clk) disable iff (!rst_n)
    (step_adv && set_end) |=> (prog_addr == loop_q)) else $error("loop return"); // R6
  AST_LOCKSTEP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (step_adv && mode_q == MODE_LOCKSTEP) |-> (out_wait == '0 && in_busy == '0 && out_level == '0)) else $error("lockstep busy"); // R9

endmodule

// File: tb/test_pe_io_sequencer.sv
module test_pe_io_sequencer;

  localparam int NLINK = 4;
  localparam int PC_W  = 4;
  localparam int DLY_W = 4;
  localparam int LVL_W = 3;
  localparam int WORD_W = 2*NLINK + DLY_W + 2;

  logic                   clk = 1'b0;
  logic                   rst_n;
  logic [2:0]             mode_sel;
  logic [PC_W-1:0]        loop_start;
  logic [PC_W-1:0]        prog_addr;
  logic [WORD_W-1:0]      prog_word;
  logic [NLINK-1:0]       rd_req, rd_done, wr_req, wr_done;
  logic [NLINK*LVL_W-1:0] out_level;
  logic [NLINK-1:0]       out_wait, in_busy;
  logic                   step_adv;

  logic [WORD_W-1:0] mem [1<<PC_W];
  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  assign prog_word = mem[prog_addr];

  pe_io_sequencer i_pe_io_sequencer (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .loop_start(loop_start),
    .prog_addr(prog_addr), .prog_word(prog_word),
    .rd_req(rd_req), .rd_done(rd_done), .wr_req(wr_req), .wr_done(wr_done),
    .out_level(out_level), .out_wait(out_wait), .in_busy(in_busy),
    .step_adv(step_adv)
  );

  function automatic logic [WORD_W-1:0] mk(input logic [3:0] rd, input logic [3:0] wr,
                                           input logic den, input logic [3:0] dly,
                                           input logic lend);
    mk = {lend, dly, den, wr, rd};
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic quiet();
    rd_done = '0; wr_done = '0; out_level = '0; out_wait = '0; in_busy = '0;
  endtask

  task automatic do_reset(input logic [2:0] m, input logic [3:0] ls);
    rst_n = 1'b0;
    mode_sel = m;
    loop_start = ls;
    quiet();
    repeat (2) @(negedge clk);
    chk(prog_addr, 0, "R1 addr in reset");
    chk({rd_req, wr_req}, 0, "R1 req in reset");
    rst_n = 1'b1;
    #1;
    chk({rd_req, wr_req}, 0, "R1 idle cycle quiet");
    @(negedge clk);
  endtask

  task automatic t_basic();
    for (int i = 0; i < 16; i++) mem[i] = '0;
    mem[0] = mk(4'b0011, 4'b0100, 1'b0, 4'd0, 1'b0);
    mem[1] = mk(4'b0000, 4'b0000, 1'b0, 4'd0, 1'b0);
    mem[2] = mk(4'b0000, 4'b0000, 1'b0, 4'd0, 1'b1);
    do_reset(3'd4, 4'd1);
    rd_done = 4'b0001; wr_done = 4'b1000;
    #1;
    chk(rd_req, 4'b0011, "R1 first-set reads pending");
    chk(wr_req, 4'b0100, "R1 first-set write pending");
    chk(step_adv, 0, "R4 hold with open ops");
    @(negedge clk);
    rd_done = 4'b0000; wr_done = 4'b0100;
    #1;
    chk(rd_req, 4'b0010, "R3 completed read retired");
    chk(wr_req, 4'b0100, "R3 write still requested");
    chk(step_adv, 0, "R4 hold with read open");
    @(negedge clk);
    rd_done = 4'b0100; wr_done = 4'b0000;
    #1;
    chk(wr_req, 4'b0000, "R3 write retired");
    chk(step_adv, 0, "R5 stray completion ignored");
    chk(prog_addr, 0, "R4 pc held");
    @(negedge clk);
    rd_done = 4'b0010;
    #1;
    chk(step_adv, 1, "R4 advance when last op done");
    @(negedge clk);
    rd_done = '0; mode_sel = 3'd0; out_wait = 4'b1111;
    #1;
    chk(prog_addr, 1, "R4 next index");
    chk(step_adv, 1, "R2 later mode change ignored");
    @(negedge clk);
    #1;
    chk(prog_addr, 2, "R4 next index again");
    @(negedge clk);
    #1;
    chk(prog_addr, 1, "R6 loop back to start");
    quiet();
  endtask

  task automatic t_delay();
    for (int i = 0; i < 16; i++) mem[i] = '0;
    mem[0] = mk(4'b0000, 4'b0000, 1'b1, 4'd3, 1'b0);
    mem[1] = mk(4'b0000, 4'b0000, 1'b1, 4'd0, 1'b1);
    do_reset(3'd4, 4'd0);
    #1; chk(step_adv, 0, "R7 delay cycle 1");
    @(negedge clk); #1; chk(step_adv, 0, "R7 delay cycle 2");
    @(negedge clk); #1; chk(step_adv, 1, "R7 delay cycle 3");
    @(negedge clk); #1; chk(prog_addr, 1, "R7 moved after delay");
    chk(step_adv, 1, "R7 zero delay as one");
    @(negedge clk); #1; chk(prog_addr, 0, "R7 loop");
    chk(step_adv, 0, "R7 delay restarts");
    do_reset(3'd1, 4'd0);
    #1; chk(step_adv, 1, "R8 delay ignored in flow mode");
    @(negedge clk); #1; chk(prog_addr, 1, "R8 advanced at once");
  endtask

  task automatic probe(input logic [11:0] lv, input logic [3:0] wt, input logic [3:0] bz,
                       input logic exp, input string tag);
    out_level = lv; out_wait = wt; in_busy = bz;
    #1;
    chk(step_adv, exp, tag);
    @(negedge clk);
  endtask

  task automatic t_modes();
    for (int i = 0; i < 16; i++) mem[i] = '0;
    mem[0] = mk(4'b0000, 4'b0000, 1'b0, 4'd0, 1'b1);
    do_reset(3'd0, 4'd0);
    probe(12'd0, 4'b0000, 4'b0000, 1'b1, "R9 lockstep quiet");
    probe(12'd1 << 6, 4'b0000, 4'b0000, 1'b0, "R9 lockstep data held");
    probe(12'd0, 4'b0001, 4'b0000, 1'b0, "R9 lockstep reader waiting");
    probe(12'd0, 4'b0000, 4'b1000, 1'b0, "R9 lockstep input busy");
    do_reset(3'd1, 4'd0);
    probe(12'd0, 4'b0000, 4'b0000, 1'b1, "R10 flow quiet");
    probe(12'd7 << 3, 4'b0000, 4'b0000, 1'b1, "R10 flow deep level");
    probe(12'd0, 4'b0000, 4'b0100, 1'b1, "R10 flow input busy");
    probe(12'd0, 4'b0010, 4'b0000, 1'b0, "R10 flow reader waiting");
    do_reset(3'd2, 4'd0);
    probe(12'd2, 4'b0000, 4'b0000, 1'b1, "R11 bounded at limit");
    probe(12'd3 << 9, 4'b0000, 4'b0000, 1'b0, "R11 bounded over limit");
    probe(12'd0, 4'b0001, 4'b0000, 1'b0, "R11 bounded reader waiting");
    probe(12'd2 | (12'd2 << 3), 4'b0000, 4'b1111, 1'b1, "R11 bounded input busy");
    do_reset(3'd3, 4'd0);
    probe(12'd0, 4'b0000, 4'b0000, 1'b0, "R12 demand without reader");
    probe(12'd0, 4'b0010, 4'b0000, 1'b1, "R12 demand reader waiting");
    probe(12'd3 << 6, 4'b0010, 4'b0000, 1'b0, "R12 demand over limit");
    do_reset(3'd6, 4'd0);
    probe(12'd0, 4'b0000, 4'b0000, 1'b1, "R13 spare code quiet");
    probe(12'd0, 4'b0000, 4'b0001, 1'b0, "R13 spare code input busy");
    quiet();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    mode_sel = '0;
    loop_start = '0;
    quiet();
    for (int i = 0; i < 16; i++) mem[i] = '0;
    @(negedge clk);
    t_basic();
    t_delay();
    t_modes();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule